// File: doc/BRIEF.md
# Indexed Effective-Address Sequencer

This block works out the effective address for three indexed operand forms of an 8-bit processor: absolute indexed by Y, zero-page pre-indexed indirect by X, and zero-page post-indexed indirect by Y. A start pulse carries a mode code, the address of the first operand byte, and the two index registers. The block then drives a synchronous read port with one read per clock. It fetches the operand bytes and the pointer bytes, and it also makes the extra throw-away read that the original silicon makes at a partly formed address. When the sequence is finished it raises a one-cycle done pulse with the 16-bit result. The order and addresses of these bus cycles are part of the contract. Advancing the program counter and the final data access belong to the surrounding core.

The state machine has these states: IDLE, OPND (operand byte read), ABS_HI (operand high byte read), ABS_DUMMY (uncorrected-address read), ZX_DUMMY (read at the unindexed zero-page address), ZX_PLO and ZX_PHI (pointer low and high byte reads at the indexed zero-page address), ZY_PLO and ZY_PHI (pointer byte reads), ZY_DUMMY (uncorrected-address read), and DONE. The transitions are:
- IDLE to OPND on an accepted start.
- OPND to ABS_HI, ZX_DUMMY or ZY_PLO, chosen by the latched mode.
- ABS_HI to ABS_DUMMY to DONE.
- ZX_DUMMY to ZX_PLO to ZX_PHI to DONE.
- ZY_PLO to ZY_PHI to ZY_DUMMY to DONE.
- DONE to IDLE, always.

Top module: `nmos_idx_agen`

## Requirements
- R1: After reset, rd_en and done are low and eff_addr is zero.
- R2: A start is taken only in IDLE and only with mode 00 (absolute,Y), 01 ((zp,X)) or 10 ((zp),Y). A start with mode 11, or a start while a sequence is running, produces no bus activity and does not change the running sequence.
- R3: The read port is synchronous: data for a read issued in cycle n appears on rd_data in cycle n+1. The first read is at opnd_addr, one cycle after the start, and reads follow one per clock with no gap until the last one.
- R4: Absolute,Y reads, in order: A (low byte L), A+1 (high byte H), and then {H, (L+Y) mod 256}. The last read happens whether or not a page is crossed. The result is ({H,L}+Y) mod 65536.
- R5: (zp,X) reads, in order: A (giving Z), {00,Z}, {00,(Z+X) mod 256} (giving L), and {00,(Z+X+1) mod 256} (giving H). The result is {H,L}.
- R6: (zp),Y reads, in order: A (giving Z), {00,Z} (giving L), {00,(Z+1) mod 256} (giving H), and then {H,(L+Y) mod 256}. The result is ({H,L}+Y) mod 65536.
- R7: All pointer arithmetic in zero page wraps inside page zero. A pointer whose low byte sits at 00FF takes its high byte from 0000.
- R8: done is high for exactly one cycle, the cycle after the last read, and rd_en is low in that cycle. eff_addr carries the result while done is high and is zero at all other times.
- R9: opnd_addr, x_idx and y_idx are sampled only with the accepted start. Later changes to them do not affect the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address computation |
| mode | input | 2 | 00 absolute,Y; 01 (zp,X); 10 (zp),Y; 11 reserved |
| opnd_addr | input | 16 | Address of the first operand byte |
| x_idx | input | 8 | X index value |
| y_idx | input | 8 | Y index value |
| rd_en | output | 1 | Read strobe, one per busy cycle |
| rd_addr | output | 16 | Read address |
| rd_data | input | 8 | Read data, valid the cycle after the strobe |
| done | output | 1 | One-cycle completion pulse |
| eff_addr | output | 16 | Effective address, valid with done |

## Verification
The assertions rely on rd_data being the reply to the previous cycle's read, so each data-dependent address check compares against that reply. They also assume that opnd_addr and the index values seen at an accepted start are the ones that matter. The bench's memory model is a pure function of the address, and it answers with a one-cycle latency. The bench scrambles opnd_addr, the indices and mode after every start, so a design that samples them late disagrees with the expected trace. It also pulses start during busy cycles with a different mode. Directed cases choose the model's contents so that pointers fall on 00FF, and so that indexing crosses a page.

// File: rtl/nmos_idx_agen_pkg.sv
package nmos_idx_agen_pkg;

    typedef enum logic [1:0] {
        M_ABSY = 2'b00,
        M_ZPXI = 2'b01,
        M_ZPIY = 2'b10,
        M_RSVD = 2'b11
    } agen_mode_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_OPND,
        S_ABS_HI,
        S_ABS_DUMMY,
        S_ZX_DUMMY,
        S_ZX_PLO,
        S_ZX_PHI,
        S_ZY_PLO,
        S_ZY_PHI,
        S_ZY_DUMMY,
        S_DONE
    } agen_state_t;

endpackage

// File: rtl/nmos_idx_agen_seq.sv
module nmos_idx_agen_seq
    import nmos_idx_agen_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  mode,
    output agen_state_t state,
    output agen_mode_t  mode_r,
    output logic        accept,
    output logic        rd_en,
    output logic        done
);

    agen_state_t state_nx;

    // a start counts only from IDLE and only with a defined mode
    assign accept = (state == S_IDLE) && start && (mode != M_RSVD);

    // state register and latched mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            mode_r <= M_ABSY;
        end else begin
            state <= state_nx;
            if (accept) begin
                mode_r <= agen_mode_t'(mode);
            end
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (accept) state_nx = S_OPND;
            S_OPND: begin
                case (mode_r)
                    M_ZPXI:  state_nx = S_ZX_DUMMY;
                    M_ZPIY:  state_nx = S_ZY_PLO;
                    default: state_nx = S_ABS_HI;
                endcase
            end
            S_ABS_HI:    state_nx = S_ABS_DUMMY;
            S_ABS_DUMMY: state_nx = S_DONE;
            S_ZX_DUMMY:  state_nx = S_ZX_PLO;
            S_ZX_PLO:    state_nx = S_ZX_PHI;
            S_ZX_PHI:    state_nx = S_DONE;
            S_ZY_PLO:    state_nx = S_ZY_PHI;
            S_ZY_PHI:    state_nx = S_ZY_DUMMY;
            S_ZY_DUMMY:  state_nx = S_DONE;
            S_DONE:      state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        rd_en = 1'b0;
        done  = 1'b0;
        unique case (state)
            S_IDLE:  ;
            S_DONE:  done = 1'b1;
            default: rd_en = 1'b1;
        endcase
    end

endmodule

// File: rtl/nmos_idx_agen_path.sv
module nmos_idx_agen_path
    import nmos_idx_agen_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  agen_state_t           state,
    input  agen_mode_t            mode_r,
    input  logic [2*DATA_W-1:0]   opnd_addr,
    input  logic [DATA_W-1:0]     x_idx,
    input  logic [DATA_W-1:0]     y_idx,
    input  logic [DATA_W-1:0]     rd_data,
    output logic [2*DATA_W-1:0]   rd_addr,
    output logic [2*DATA_W-1:0]   eff_addr
);

    localparam int AW = 2 * DATA_W;
    localparam logic [DATA_W-1:0] ZPAGE = '0;
    localparam logic [DATA_W-1:0] ONE_B = DATA_W'(1);

    logic [AW-1:0]     base_r;
    logic [DATA_W-1:0] x_r, y_r, zp_r, lo_r, hi_r;

    logic [DATA_W-1:0] lo_plus_y, zp_plus_x, zp_plus_x1, zp_plus_1;
    logic [AW-1:0]     ptr_plus_y;

    // sample the request and catch each returned byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_r <= '0;
            x_r    <= '0;
            y_r    <= '0;
            zp_r   <= '0;
            lo_r   <= '0;
            hi_r   <= '0;
        end else begin
            if (accept) begin
                base_r <= opnd_addr;
                x_r    <= x_idx;
                y_r    <= y_idx;
            end
            unique case (state)
                S_ABS_HI:    lo_r <= rd_data;
                S_ABS_DUMMY: hi_r <= rd_data;
                S_ZX_DUMMY:  zp_r <= rd_data;
                S_ZX_PHI:    lo_r <= rd_data;
                S_ZY_PLO:    zp_r <= rd_data;
                S_ZY_PHI:    lo_r <= rd_data;
                S_ZY_DUMMY:  hi_r <= rd_data;
                default:     ;
            endcase
        end
    end

    // byte-wide sums wrap inside the page
    assign lo_plus_y  = lo_r + y_r;
    assign zp_plus_x  = zp_r + x_r;
    assign zp_plus_x1 = zp_plus_x + ONE_B;
    assign zp_plus_1  = zp_r + ONE_B;
    assign ptr_plus_y = {hi_r, lo_r} + {ZPAGE, y_r};

    // read address per bus cycle
    always_comb begin
        rd_addr = '0;
        unique case (state)
            S_OPND:      rd_addr = base_r;
            S_ABS_HI:    rd_addr = base_r + AW'(1);
            S_ABS_DUMMY: rd_addr = {rd_data, lo_plus_y};
            S_ZX_DUMMY:  rd_addr = {ZPAGE, rd_data};
            S_ZX_PLO:    rd_addr = {ZPAGE, zp_plus_x};
            S_ZX_PHI:    rd_addr = {ZPAGE, zp_plus_x1};
            S_ZY_PLO:    rd_addr = {ZPAGE, rd_data};
            S_ZY_PHI:    rd_addr = {ZPAGE, zp_plus_1};
            S_ZY_DUMMY:  rd_addr = {rd_data, lo_plus_y};
            default:     rd_addr = '0;
        endcase
    end

    // result, only presented in DONE
    always_comb begin
        eff_addr = '0;
        if (state == S_DONE) begin
            if (mode_r == M_ZPXI) begin
                eff_addr = {rd_data, lo_r};
            end else begin
                eff_addr = ptr_plus_y;
            end
        end
    end

endmodule

// File: rtl/nmos_idx_agen.sv
module nmos_idx_agen
    import nmos_idx_agen_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          mode,
    input  logic [2*DATA_W-1:0] opnd_addr,
    input  logic [DATA_W-1:0]   x_idx,
    input  logic [DATA_W-1:0]   y_idx,
    output logic                rd_en,
    output logic [2*DATA_W-1:0] rd_addr,
    input  logic [DATA_W-1:0]   rd_data,
    output logic                done,
    output logic [2*DATA_W-1:0] eff_addr
);

    agen_state_t state;
    agen_mode_t  mode_r;
    logic        accept;

    nmos_idx_agen_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .mode   (mode),
        .state  (state),
        .mode_r (mode_r),
        .accept (accept),
        .rd_en  (rd_en),
        .done   (done)
    );

    nmos_idx_agen_path #(.DATA_W(DATA_W)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .state     (state),
        .mode_r    (mode_r),
        .opnd_addr (opnd_addr),
        .x_idx     (x_idx),
        .y_idx     (y_idx),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .eff_addr  (eff_addr)
    );

endmodule

// File: rtl/nmos_idx_agen_chk.sv
module nmos_idx_agen_chk #(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [1:0]          mode,
    input logic [2*DATA_W-1:0] opnd_addr,
    input logic [DATA_W-1:0]   x_idx,
    input logic [DATA_W-1:0]   y_idx,
    input logic                rd_en,
    input logic [2*DATA_W-1:0] rd_addr,
    input logic [DATA_W-1:0]   rd_data,
    input logic                done,
    input logic [2*DATA_W-1:0] eff_addr
);

    localparam logic [DATA_W-1:0] ZPAGE = '0;

    logic                idle_c, acc_c;
    logic [1:0]          mode_c;
    logic [2*DATA_W-1:0] base_c;
    logic [DATA_W-1:0]   x_c, y_c, lo_c, zp_c;
    logic [2:0]          cnt;

    assign idle_c = !rd_en && !done;
    assign acc_c  = start && idle_c && (mode != 2'b11);

    // independent tracking of the request and the read index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_c <= '0;
            base_c <= '0;
            x_c    <= '0;
            y_c    <= '0;
            lo_c   <= '0;
            zp_c   <= '0;
            cnt    <= '0;
        end else if (acc_c) begin
            mode_c <= mode;
            base_c <= opnd_addr;
            x_c    <= x_idx;
            y_c    <= y_idx;
            cnt    <= '0;
        end else if (rd_en) begin
            cnt <= cnt + 3'd1;
            if (cnt == 3'd1) begin
                lo_c <= rd_data;
                zp_c <= rd_data;
            end
        end
    end

    assert_first_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_c |=> rd_en && (rd_addr == $past(opnd_addr)));

    assert_reserved_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle_c && mode == 2'b11) |=> !rd_en);

    assert_abs_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode_c == 2'b00 && cnt == 3'd1) |-> (rd_addr == base_c + 1'b1));

    assert_abs_dummy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode_c == 2'b00 && cnt == 3'd2) |-> (rd_addr == {rd_data, lo_c + y_c}));

    assert_zx_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode_c == 2'b01 && cnt == 3'd2) |-> (rd_addr == {ZPAGE, zp_c + x_c}));

    assert_zp_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cnt != 3'd0 && (mode_c == 2'b01 || (mode_c == 2'b10 && cnt < 3'd3)))
        |-> (rd_addr[2*DATA_W-1:DATA_W] == ZPAGE));

    assert_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && done));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt == ((mode_c == 2'b00) ? 3'd3 : 3'd4)));

    assert_eff_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (eff_addr == '0));

endmodule

bind nmos_idx_agen nmos_idx_agen_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_nmos_idx_agen.sv
module sim_nmos_idx_agen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [15:0] opnd_addr = '0;
    logic [7:0]  x_idx = '0;
    logic [7:0]  y_idx = '0;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data = '0;
    logic        done;
    logic [15:0] eff_addr;

    int   n_chk = 0;
    int   n_bad = 0;
    logic [7:0] salt = 8'h00;

    always #5 clk = ~clk;

    nmos_idx_agen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .opnd_addr(opnd_addr), .x_idx(x_idx), .y_idx(y_idx),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .eff_addr(eff_addr)
    );

    // memory contents as a pure function of the address
    function automatic logic [7:0] memf(input logic [15:0] a);
        logic [7:0] s;
        s = 8'(a[7:0] * 8'd13) + 8'(a[15:8] * 8'd71) + salt;
        return s;
    endfunction

    // choose salt so that memf(a) == v
    task automatic force_byte(input logic [15:0] a, input logic [7:0] v);
        salt = 8'h00;
        salt = v - memf(a);
    endtask

    always @(posedge clk) begin
        if (rd_en) rd_data <= memf(rd_addr);
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    task automatic run_txn(input logic [1:0] m, input logic [15:0] op,
                           input logic [7:0] x, input logic [7:0] y,
                           input bit glitch, input string tag);
        logic [15:0] seen [8];
        logic [15:0] expa [4];
        logic [15:0] eff_seen, eff_exp;
        logic [7:0]  z, lo, hi;
        int n, n_exp, done_at;
        bit got_done, gap;
        n = 0; done_at = 0; got_done = 0; gap = 0; eff_seen = '0;
        for (int i = 0; i < 8; i++) seen[i] = '0;

        // expected trace from the requirements
        for (int i = 0; i < 4; i++) expa[i] = '0;
        if (m == 2'b00) begin
            lo = memf(op); hi = memf(op + 16'd1);
            expa[0] = op; expa[1] = op + 16'd1; expa[2] = {hi, 8'(lo + y)};
            eff_exp = {hi, lo} + {8'h00, y}; n_exp = 3;
        end else if (m == 2'b01) begin
            z = memf(op);
            lo = memf({8'h00, 8'(z + x)}); hi = memf({8'h00, 8'(z + x + 8'd1)});
            expa[0] = op; expa[1] = {8'h00, z};
            expa[2] = {8'h00, 8'(z + x)}; expa[3] = {8'h00, 8'(z + x + 8'd1)};
            eff_exp = {hi, lo}; n_exp = 4;
        end else begin
            z = memf(op);
            lo = memf({8'h00, z}); hi = memf({8'h00, 8'(z + 8'd1)});
            expa[0] = op; expa[1] = {8'h00, z};
            expa[2] = {8'h00, 8'(z + 8'd1)}; expa[3] = {hi, 8'(lo + y)};
            eff_exp = {hi, lo} + {8'h00, y}; n_exp = 4;
        end

        @(negedge clk);
        start = 1'b1; mode = m; opnd_addr = op; x_idx = x; y_idx = y;
        for (int cyc = 1; cyc <= 8 && !got_done; cyc++) begin
            @(negedge clk);
            if (rd_en) begin
                if (n != cyc - 1) gap = 1;
                if (n < 8) seen[n] = rd_addr;
                n++;
            end
            if (done) begin
                got_done = 1; done_at = cyc; eff_seen = eff_addr;
            end
            // R9: disturb the inputs once the request is taken
            start = 1'b0;
            opnd_addr = 16'($urandom); x_idx = 8'($urandom); y_idx = 8'($urandom);
            mode = 2'($urandom);
            // R2: a start during the sequence must be ignored
            if (glitch && (cyc == 1 || cyc == 2)) begin
                start = 1'b1; mode = m + 2'd1;
            end
        end
        chk(n == n_exp, {tag, " R3 read count"}, n, n_exp);
        chk(!gap, {tag, " R3 reads back to back"}, gap, 0);
        for (int i = 0; i < 4; i++) begin
            if (i < n_exp) chk(seen[i] == expa[i], {tag, $sformatf(" bus read %0d", i)}, seen[i], expa[i]);
        end
        chk(got_done && done_at == n_exp + 1, {tag, " R8 done timing"}, done_at, n_exp + 1);
        chk(eff_seen == eff_exp, {tag, " effective address"}, eff_seen, eff_exp);
        start = 1'b0;
        @(negedge clk);
        chk(!done && !rd_en && eff_addr == 16'h0, {tag, " R8 quiet after done"}, {done, rd_en, eff_addr}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R3 watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!rd_en && !done && eff_addr == 16'h0, "R1 reset outputs", {rd_en, done, eff_addr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_en && !done && eff_addr == 16'h0, "R1 idle after reset", {rd_en, done, eff_addr}, 0);

        // R4 page crossing and not
        force_byte(16'h1234, 8'hF0);
        run_txn(2'b00, 16'h1234, 8'h00, 8'h20, 0, "R4 abs cross");
        run_txn(2'b00, 16'h1234, 8'h00, 8'h05, 0, "R4 abs no-cross");
        // R5 and R7: pointer at 00FF, and zp+X wrapping
        force_byte(16'h0300, 8'hF0);
        run_txn(2'b01, 16'h0300, 8'h0F, 8'h00, 0, "R5 R7 zpx ptr at FF");
        run_txn(2'b01, 16'h0300, 8'h20, 8'h00, 0, "R5 R7 zpx wrap");
        // R6 and R7: pointer at 00FF
        force_byte(16'h0400, 8'hFF);
        run_txn(2'b10, 16'h0400, 8'h00, 8'h80, 0, "R6 R7 zpy ptr at FF");
        // R6: force pointer low byte high so that +Y crosses
        force_byte(16'h0010, 8'hE0);
        force_byte({8'h00, memf(16'h0500)}, 8'hF8);
        run_txn(2'b10, 16'h0500, 8'h00, 8'h40, 0, "R6 zpy");
        // R2 reserved mode does nothing
        @(negedge clk);
        start = 1'b1; mode = 2'b11;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(!rd_en && !done, "R2 reserved mode ignored", {rd_en, done}, 0);
            @(negedge clk);
        end
        // R2 start while busy ignored
        run_txn(2'b00, 16'hABCD, 8'h11, 8'hFF, 1, "R2 busy start abs");
        run_txn(2'b01, 16'h00FE, 8'h33, 8'h44, 1, "R2 busy start zpx");
        // random mix
        for (int t = 0; t < 60; t++) begin
            logic [1:0] m;
            m = 2'($urandom % 3);
            salt = 8'($urandom);
            run_txn(m, 16'($urandom), 8'($urandom), 8'($urandom), ($urandom % 4) == 0,
                    (m == 2'b00) ? "R4 rand" : (m == 2'b01) ? "R5 rand" : "R6 rand");
        end
        finish_run();
    end

endmodule